// File: doc/BRIEF.md
# Up-Counting Timer with Buffered Reload

This block is a general-purpose timer that counts upward. Software sets it up through a small register bus with single-cycle writes and combinational reads. A programmable divider turns the clock into count ticks. The counter climbs from zero to an active top value, then wraps to zero and raises an update event. Each update event sets a sticky flag, and the flag can drive a level interrupt.

The top value can be written straight into the active copy or held in a buffer until the next update event, so a new period never cuts into the one in progress. The divider value is always buffered. Software can force an update event at any time. This restarts the divider and the counter and copies both buffers into use.

In single-shot mode the timer clears its own enable at the end of the first period. The counter width is a parameter, either 16 or 32 bits. Software finds the width by writing all ones to the top register and reading the value back.

Top module: `uptimer`

## Requirements
- R1: After reset every register reads 0 and `irq` is low.
- R2: Register map. Control is at 0x00: bit 0 is the run enable, bit 3 is single-shot, bit 7 buffers the top value, and all other bits read 0. Interrupt enable is at 0x0C, bit 0. Status is at 0x10, bit 0 is the update flag. The event register at 0x14 always reads 0. The divider is at 0x28 and holds PSC_W bits. The top value is at 0x2C. Unmapped addresses read 0.
- R3: Writing all ones to 0x2C reads back 2^CNT_W-1. That is 0xFFFF for CNT_W=16 and 0xFFFFFFFF for CNT_W=32.
- R4: With divider value P and top value A, update events come every (P+1)*(A+1) clocks while run is set. The first event comes (P+1)*(A+1) clocks after the write that sets run, when that write follows a forced update. While run is clear the counter holds.
- R5: With single-shot set, the first counter-reached-top event clears control bit 0, and bit 3 stays set. No further events follow.
- R6: With buffering off, a write to 0x2C changes the active top value at once. The period in progress then ends when the counter reaches the new value.
- R7: With buffering on, a write to 0x2C takes effect only at the next update event.
- R8: Writing 1 to bit 0 of 0x14 is a forced update. It zeroes the counter and the divider phase, loads the buffered divider and top values, and sets the flag in the same cycle. It does not change the run enable.
- R9: Writing 0 to status bit 0 clears the flag. Writing 1 has no effect. An update event in the same cycle as a clear wins, and the flag stays set.
- R10: `irq` is high exactly when the flag and interrupt enable bit 0 are both set.
- R11: A divider write takes effect only at the next update event, whether counter-driven or forced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq | output | 1 | Level interrupt: flag and enable both set |

## Verification
The bench builds the main instance with CNT_W=16 and PSC_W=16. A second instance with CNT_W=32 is used only for the width readback. Divider values 0 to 3 and top values 0 to 5 keep every period below 25 clocks. The bench can therefore sweep all 24 pairs in both single-shot and free-running modes, and measure each period edge by edge against (P+1)*(A+1). The pair 0/0 gives an event on every clock, which makes a flag set and a software clear collide in the same cycle.

// File: rtl/uptimer_pkg.sv
package uptimer_pkg;

  localparam logic [7:0] OFS_CTRL  = 8'h00;
  localparam logic [7:0] OFS_IEN   = 8'h0C;
  localparam logic [7:0] OFS_STAT  = 8'h10;
  localparam logic [7:0] OFS_EVGEN = 8'h14;
  localparam logic [7:0] OFS_DIV   = 8'h28;
  localparam logic [7:0] OFS_TOP   = 8'h2C;

  localparam int BIT_RUN    = 0;
  localparam int BIT_SINGLE = 3;
  localparam int BIT_BUFTOP = 7;

  // divider phase has reached the programmed ratio
  function automatic logic div_hit(logic [31:0] phase, logic [31:0] ratio);
    return phase == ratio;
  endfunction

  // next counter value on a tick: wrap at top, else step up
  function automatic logic [31:0] count_step(logic [31:0] c, logic [31:0] top);
    return (c == top) ? 32'd0 : c + 32'd1;
  endfunction

endpackage

// File: rtl/uptimer_regs.sv
module uptimer_regs
  import uptimer_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int PSC_W  = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              natural_upd,
  input  logic              upd,
  output logic              run,
  output logic              single,
  output logic              buftop,
  output logic              uie,
  output logic              uflag,
  output logic [PSC_W-1:0]  div_buf,
  output logic [CNT_W-1:0]  top_buf,
  output logic              top_wr,
  output logic              force_upd
);

  logic wr_ctrl, wr_ien, wr_stat, wr_evgen, wr_div;

  assign wr_ctrl  = bus_wr && (bus_addr == ADDR_W'(OFS_CTRL));
  assign wr_ien   = bus_wr && (bus_addr == ADDR_W'(OFS_IEN));
  assign wr_stat  = bus_wr && (bus_addr == ADDR_W'(OFS_STAT));
  assign wr_evgen = bus_wr && (bus_addr == ADDR_W'(OFS_EVGEN));
  assign wr_div   = bus_wr && (bus_addr == ADDR_W'(OFS_DIV));
  assign top_wr   = bus_wr && (bus_addr == ADDR_W'(OFS_TOP));
  assign force_upd = wr_evgen && bus_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run     <= 1'b0;
      single  <= 1'b0;
      buftop  <= 1'b0;
      uie     <= 1'b0;
      uflag   <= 1'b0;
      div_buf <= '0;
      top_buf <= '0;
    end else begin
      if (wr_ctrl) begin
        run    <= bus_wdata[BIT_RUN];
        single <= bus_wdata[BIT_SINGLE];
        buftop <= bus_wdata[BIT_BUFTOP];
      end else if (natural_upd && single) begin
        run <= 1'b0;
      end
      if (wr_ien) uie <= bus_wdata[0];
      if (upd) uflag <= 1'b1;
      else if (wr_stat && !bus_wdata[0]) uflag <= 1'b0;
      if (wr_div) div_buf <= bus_wdata[PSC_W-1:0];
      if (top_wr) top_buf <= bus_wdata[CNT_W-1:0];
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      ADDR_W'(OFS_CTRL): begin
        bus_rdata[BIT_RUN]    = run;
        bus_rdata[BIT_SINGLE] = single;
        bus_rdata[BIT_BUFTOP] = buftop;
      end
      ADDR_W'(OFS_IEN):  bus_rdata[0] = uie;
      ADDR_W'(OFS_STAT): bus_rdata[0] = uflag;
      ADDR_W'(OFS_DIV):  bus_rdata[PSC_W-1:0] = div_buf;
      ADDR_W'(OFS_TOP):  bus_rdata[CNT_W-1:0] = top_buf;
      default:           bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/uptimer_prescaler.sv
module uptimer_prescaler
  import uptimer_pkg::*;
#(
  parameter int PSC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             force_upd,
  input  logic             upd,
  input  logic [PSC_W-1:0] div_buf,
  output logic [PSC_W-1:0] phase,
  output logic [PSC_W-1:0] div_act,
  output logic             tick
);

  assign tick = run && div_hit(32'(phase), 32'(div_act));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= '0;
      div_act <= '0;
    end else begin
      if (force_upd)  phase <= '0;
      else if (tick)  phase <= '0;
      else if (run)   phase <= phase + 1'b1;
      if (upd) div_act <= div_buf;
    end
  end

endmodule

// File: rtl/uptimer_counter.sv
module uptimer_counter
  import uptimer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             force_upd,
  input  logic             top_wr,
  input  logic [CNT_W-1:0] top_wdata,
  input  logic             buftop,
  input  logic [CNT_W-1:0] top_buf,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] top_act,
  output logic             natural_upd,
  output logic             upd
);

  assign natural_upd = tick && (cnt == top_act);
  assign upd         = force_upd || natural_upd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      top_act <= '0;
    end else begin
      if (force_upd) cnt <= '0;
      else if (tick) cnt <= CNT_W'(count_step(32'(cnt), 32'(top_act)));
      if (top_wr && !buftop) top_act <= top_wdata;
      else if (upd)          top_act <= top_buf;
    end
  end

endmodule

// File: rtl/uptimer.sv
module uptimer #(
  parameter int CNT_W  = 16,
  parameter int PSC_W  = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq
);

  logic             run, single, buftop, uie, uflag;
  logic             top_wr, force_upd, tick, natural_upd, upd;
  logic [PSC_W-1:0] div_buf, div_act, phase;
  logic [CNT_W-1:0] top_buf, top_act, cnt;

  uptimer_regs #(.CNT_W(CNT_W), .PSC_W(PSC_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .natural_upd(natural_upd), .upd(upd),
    .run(run), .single(single), .buftop(buftop), .uie(uie), .uflag(uflag),
    .div_buf(div_buf), .top_buf(top_buf), .top_wr(top_wr), .force_upd(force_upd)
  );

  uptimer_prescaler #(.PSC_W(PSC_W)) u_div (
    .clk(clk), .rst_n(rst_n), .run(run), .force_upd(force_upd), .upd(upd),
    .div_buf(div_buf), .phase(phase), .div_act(div_act), .tick(tick)
  );

  uptimer_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .force_upd(force_upd),
    .top_wr(top_wr), .top_wdata(bus_wdata[CNT_W-1:0]), .buftop(buftop),
    .top_buf(top_buf), .cnt(cnt), .top_act(top_act),
    .natural_upd(natural_upd), .upd(upd)
  );

  assign irq = uflag && uie;

endmodule

// File: rtl/uptimer_chk.sv
module uptimer_chk #(
  parameter int CNT_W  = 16,
  parameter int PSC_W  = 16,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              irq,
  input logic              run,
  input logic              single,
  input logic              uie,
  input logic              uflag,
  input logic              tick,
  input logic              force_upd,
  input logic              natural_upd,
  input logic [PSC_W-1:0]  phase,
  input logic [PSC_W-1:0]  div_act,
  input logic [CNT_W-1:0]  cnt
);

  logic ctrl_wr;
  assign ctrl_wr = bus_wr && (bus_addr == '0);

  p_phase_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    phase <= div_act);

  p_cnt_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !force_upd && !natural_upd) |=> cnt == CNT_W'($past(cnt) + 1'b1));

  p_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (natural_upd && !force_upd) |=> cnt == '0);

  p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !force_upd) |=> $stable(cnt));

  p_single_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (natural_upd && single && !ctrl_wr) |=> !run);

  p_force_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    force_upd |=> (cnt == '0 && phase == '0 && uflag));

  p_flag_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    natural_upd |=> uflag);

  p_irq_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !uie |-> !irq);

  p_irq_on_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (uie && uflag) |-> irq);

endmodule

bind uptimer uptimer_chk #(.CNT_W(CNT_W), .PSC_W(PSC_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr), .irq(irq),
  .run(run), .single(single), .uie(uie), .uflag(uflag), .tick(tick),
  .force_upd(force_upd), .natural_upd(natural_upd), .phase(phase),
  .div_act(div_act), .cnt(cnt)
);

// File: tb/uptimer_tb.sv
`timescale 1ns/1ps
module uptimer_tb;

  localparam logic [7:0] A_CTRL = 8'h00, A_IEN = 8'h0C, A_STAT = 8'h10;
  localparam logic [7:0] A_EVG = 8'h14, A_DIV = 8'h28, A_TOP = 8'h2C;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bwr = 1'b0;
  logic [7:0]  baddr = 8'h00;
  logic [31:0] bwdata = '0;
  logic [31:0] brdata;
  logic        irq;

  logic        w_wr = 1'b0;
  logic [7:0]  w_addr = 8'h00;
  logic [31:0] w_wdata = '0;
  logic [31:0] w_rdata;
  logic        w_irq;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  uptimer #(.CNT_W(16), .PSC_W(16), .ADDR_W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bwr), .bus_addr(baddr),
    .bus_wdata(bwdata), .bus_rdata(brdata), .irq(irq)
  );

  uptimer #(.CNT_W(32), .PSC_W(16), .ADDR_W(8)) u_dut_w32 (
    .clk(clk), .rst_n(rst_n), .bus_wr(w_wr), .bus_addr(w_addr),
    .bus_wdata(w_wdata), .bus_rdata(w_rdata), .irq(w_irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bwr = 1'b1; baddr = a; bwdata = d;
    @(posedge clk);
    #1 bwr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    baddr = a;
    #1 d = brdata;
  endtask

  task automatic wait_irq(input int lim, output int n);
    n = 0;
    do begin
      @(posedge clk);
      #1 n++;
    end while (!irq && n < lim);
  endtask

  task automatic rearm(input logic [31:0] p, input logic [31:0] a);
    wr(A_CTRL, 0); wr(A_DIV, p); wr(A_TOP, a); wr(A_EVG, 1); wr(A_STAT, 0);
  endtask

  initial begin
    logic [31:0] v;
    int n;
    int per;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    rd(A_CTRL, v); chk("R1 ctrl", v, 0);
    rd(A_IEN, v);  chk("R1 ien", v, 0);
    rd(A_STAT, v); chk("R1 stat", v, 0);
    rd(A_DIV, v);  chk("R1 div", v, 0);
    rd(A_TOP, v);  chk("R1 top", v, 0);
    chk("R1 irq", {31'd0, irq}, 0);

    // R2 register map readback
    wr(A_CTRL, 32'hFFFF_FF76); rd(A_CTRL, v); chk("R2 ctrl other bits", v, 0);
    wr(A_CTRL, 32'hFFFF_FFFE); rd(A_CTRL, v); chk("R2 ctrl bits 3,7", v, 32'h88);
    wr(A_CTRL, 0);
    wr(A_DIV, 32'hFFFF_FFFF); rd(A_DIV, v); chk("R2 div width", v, 32'hFFFF);
    wr(A_IEN, 32'hFFFF_FFFF); rd(A_IEN, v); chk("R2 ien", v, 1);
    rd(A_EVG, v); chk("R2 evgen reads 0", v, 0);
    rd(8'h04, v); chk("R2 unmapped", v, 0);

    // R3 width discovery on both widths
    wr(A_TOP, 32'hFFFF_FFFF); rd(A_TOP, v); chk("R3 16-bit top", v, 32'hFFFF);
    @(negedge clk); w_wr = 1'b1; w_addr = A_TOP; w_wdata = 32'hFFFF_FFFF;
    @(negedge clk); w_wr = 1'b0; #1 chk("R3 32-bit top", w_rdata, 32'hFFFF_FFFF);

    // R4 / R5 / R9 sweep over divider and top values
    wr(A_IEN, 1);
    for (int p = 0; p < 4; p++) begin
      for (int a = 0; a < 6; a++) begin
        per = (p + 1) * (a + 1);
        rearm(p, a);
        wr(A_CTRL, 32'h9);
        wait_irq(200, n); chk($sformatf("R5 single period p=%0d a=%0d", p, a), n, per);
        rd(A_CTRL, v); chk("R5 run cleared", v, 32'h8);
        wr(A_STAT, 0);
        wait_irq(40, n); chk("R5 no second event", {31'd0, irq}, 0);
        wr(A_CTRL, 0); wr(A_EVG, 1); wr(A_STAT, 0);
        wr(A_CTRL, 32'h1);
        wait_irq(200, n); chk($sformatf("R4 first period p=%0d a=%0d", p, a), n, per);
        wr(A_STAT, 0);
        if (per > 1) begin
          wait_irq(200, n); chk($sformatf("R4 next period p=%0d a=%0d", p, a), n, per - 1);
        end else begin
          chk("R9 set wins over clear", {31'd0, irq}, 1);
        end
      end
    end

    // R6 buffering off, also R4 hold while disabled
    rearm(0, 3);
    repeat (30) @(posedge clk);
    wr(A_CTRL, 32'h1);
    wr(A_TOP, 7);
    wait_irq(200, n); chk("R6 direct top write", n, 7);

    // R7 buffering on
    rearm(0, 3);
    wr(A_CTRL, 32'h81);
    wr(A_TOP, 7);
    wait_irq(200, n); chk("R7 old top still used", n, 3);
    wr(A_STAT, 0);
    wait_irq(200, n); chk("R7 new top after update", n, 7);

    // R11 divider buffered
    rearm(0, 1);
    wr(A_DIV, 2);
    wr(A_CTRL, 32'h1);
    wait_irq(200, n); chk("R11 old divider", n, 2);
    wr(A_STAT, 0);
    wait_irq(200, n); chk("R11 new divider", n, 5);

    // R8 forced update while running with buffered top
    rearm(1, 2);
    wr(A_CTRL, 32'h81);
    wr(A_TOP, 5);
    wr(A_EVG, 1);
    chk("R8 flag set by force", {31'd0, irq}, 1);
    wr(A_STAT, 0);
    wait_irq(200, n); chk("R8 restart with loaded values", n, 11);
    rd(A_CTRL, v); chk("R8 run unchanged", v, 32'h81);

    // R9 / R10 flag writes and interrupt gating
    wr(A_CTRL, 0); wr(A_STAT, 0); wr(A_EVG, 1);
    wr(A_STAT, 1); rd(A_STAT, v); chk("R9 write 1 keeps flag", v, 1);
    wr(A_IEN, 0); chk("R10 irq masked", {31'd0, irq}, 0);
    wr(A_IEN, 1); chk("R10 irq raised", {31'd0, irq}, 1);
    wr(A_STAT, 0); rd(A_STAT, v); chk("R9 clear", v, 0);
    chk("R10 irq low after clear", {31'd0, irq}, 0);
    wr(A_STAT, 1); rd(A_STAT, v); chk("R9 write 1 no set", v, 0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule